// File: doc/BRIEF.md
# Variable-Length DMA Channel

This block is one direct-memory-access channel. Once armed, a trigger pulse makes it copy a run of 8-bit or 16-bit units from a source address to a destination address. It uses a single synchronous memory port with a request/acknowledge handshake. Only one access is in flight at a time, and each read is followed by the matching write.

The number of units is either a fixed programmed maximum or is taken at run time from the first unit read. In the second case a 3-bit length-mode code adds a small offset to the value found there, and the result is clamped to the programmed maximum. The first unit is itself copied and counts toward the total.

At completion the channel raises a sticky done flag. If its mask allows, it also raises a shared channel-interrupt flag, and that flag drives the interrupt request while the global enable is set. In repeat mode the channel stays armed and reloads its start addresses. Otherwise it disarms.

Top module: `vlen_dma_chan`

## Requirements
- R1: With length-mode code 3'b000 or 3'b111 (also the unused codes 3'b101 and 3'b110), exactly `cfg_max_len` units are copied. A programmed maximum of zero finishes without any memory access.
- R2: With code 3'b001 the count is n+1, with 3'b010 it is n, with 3'b011 it is n+2 and with 3'b100 it is n+3. Here n is the length value held in the first unit read.
- R3: For the four variable codes, when n >= `cfg_max_len` the count is `cfg_max_len` instead of the formula.
- R4: In byte mode (`cfg_word`=0), n is bits [7:0] of the first unit when `cfg_n7`=0 and bits [6:0] when `cfg_n7`=1. Bytes are written with `mem_wdata[15:8]`=0.
- R5: In word mode (`cfg_word`=1), n is bits [12:0] of the first 16-bit unit, and the whole word is copied.
- R6: The first unit is written to the destination like every other unit. Both addresses advance by 1 per byte or by 2 per word, so unit i goes from source base + i*step to destination base + i*step.
- R7: A computed variable count of zero ends the transfer right after the first read, with no write.
- R8: At completion `chan_done` becomes 1. It stays 1 until a `done_clr` pulse, which also clears `dma_flag`.
- R9: `dma_flag` is set at completion only when `cfg_irq_mask`=1. `dma_irq` is 1 exactly when `dma_flag`=1 and `irq_en`=1.
- R10: At completion the channel stays armed and reloads both start addresses when `cfg_repeat`=1. It disarms when `cfg_repeat`=0.
- R11: A trigger starts a transfer only when the channel is armed and idle. A trigger while disarmed or while busy has no effect.
- R12: `mem_req` is held, with stable `mem_addr` and `mem_we`, until `mem_ack`. Read data is taken in the acknowledge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_src_base | input | ADDR_W | Source start address |
| cfg_dst_base | input | ADDR_W | Destination start address |
| cfg_max_len | input | LEN_W | Fixed count or clamp limit |
| cfg_len_mode | input | 3 | Length-mode code |
| cfg_word | input | 1 | 1 = 16-bit units, 0 = bytes |
| cfg_n7 | input | 1 | Byte mode: take n from 7 bits |
| cfg_repeat | input | 1 | 1 = re-arm at completion |
| cfg_irq_mask | input | 1 | Allow completion to set the shared flag |
| irq_en | input | 1 | Global channel-interrupt enable |
| arm_set | input | 1 | Pulse: arm and load start addresses |
| trig | input | 1 | Pulse: start a transfer |
| done_clr | input | 1 | Pulse: clear done and shared flags |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Access address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access accepted / read data valid |
| mem_rdata | input | DATA_W | Read data |
| chan_armed | output | 1 | Channel armed |
| chan_busy | output | 1 | Transfer in progress |
| chan_done | output | 1 | Sticky completion flag |
| dma_flag | output | 1 | Shared interrupt flag |
| dma_irq | output | 1 | Interrupt request |

## Verification
The assertions watch the behaviours that show on every cycle:
- the request stays held with a stable address until it is acknowledged,
- the done flag stays sticky until cleared,
- the shared flag rises only when the mask allows it,
- a write never happens once the unit counter has reached the count,
- the channel is never busy while disarmed, and a trigger to a disarmed channel leaves it idle.

Only the bench scenarios can show the correct count for each length code, the clamp, the byte and word length fields, the destination contents, the zero-length exit, and the address reload on re-arm.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_FIN} vdma_st_e;

    localparam logic [2:0] LM_FIXED_LO = 3'b000;
    localparam logic [2:0] LM_PLUS1    = 3'b001;
    localparam logic [2:0] LM_PLUS0    = 3'b010;
    localparam logic [2:0] LM_PLUS2    = 3'b011;
    localparam logic [2:0] LM_PLUS3    = 3'b100;
    localparam logic [2:0] LM_FIXED_HI = 3'b111;

    function automatic logic mode_is_var(input logic [2:0] code);
        return (code == LM_PLUS1) || (code == LM_PLUS0) ||
               (code == LM_PLUS2) || (code == LM_PLUS3);
    endfunction
endpackage

// File: rtl/vdma_len_calc.sv
module vdma_len_calc
    import vdma_pkg::*;
#(
    parameter int LEN_W    = 13,
    parameter int DATA_W   = 16,
    parameter int WORD_N_W = 13,
    localparam int CNT_W   = LEN_W + 1
) (
    input  logic [2:0]        len_mode,
    input  logic [LEN_W-1:0]  max_len,
    input  logic              word_mode,
    input  logic              n7_sel,
    input  logic [DATA_W-1:0] first_unit,
    output logic              var_mode,
    output logic [CNT_W-1:0]  fixed_cnt,
    output logic [CNT_W-1:0]  var_cnt
);
    logic [CNT_W-1:0] n_val;
    logic [CNT_W-1:0] lim;
    logic [CNT_W-1:0] offs;

    always_comb begin
        lim       = CNT_W'(max_len);
        fixed_cnt = lim;
        var_mode  = mode_is_var(len_mode);
        if (word_mode)   n_val = CNT_W'(first_unit[WORD_N_W-1:0]);
        else if (n7_sel) n_val = CNT_W'(first_unit[6:0]);
        else             n_val = CNT_W'(first_unit[7:0]);
        case (len_mode)
            LM_PLUS1: offs = CNT_W'(1);
            LM_PLUS2: offs = CNT_W'(2);
            LM_PLUS3: offs = CNT_W'(3);
            default:  offs = '0;
        endcase
        if (!var_mode || n_val >= lim) var_cnt = lim;
        else                           var_cnt = n_val + offs;
    end

    // R3
    always_comb begin
        if (var_mode && n_val >= lim)
            clamp_chk: assert (var_cnt == lim);
    end
endmodule

// File: rtl/vdma_flags.sv
module vdma_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic fin,
    input  logic irq_mask,
    input  logic irq_en,
    input  logic clr,
    output logic done,
    output logic flag,
    output logic irq
);
    typedef struct packed {
        logic done;
        logic flag;
    } flg_t;

    flg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (clr) begin
            f_d.done = 1'b0;
            f_d.flag = 1'b0;
        end
        if (fin) begin
            f_d.done = 1'b1;
            if (irq_mask) f_d.flag = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign done = f_q.done;
    assign flag = f_q.flag;
    assign irq  = f_q.flag & irq_en;

    // R8
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_q.done && !clr) |=> f_q.done);
    // R9
    flag_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!f_q.flag && !fin) |=> !f_q.flag);
    // R9
    flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fin && !irq_mask && !f_q.flag) |=> !f_q.flag);
endmodule

// File: rtl/vlen_dma_chan.sv
module vlen_dma_chan
    import vdma_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 13,
    parameter int DATA_W = 16,
    parameter int WORD_N_W = 13,
    localparam int CNT_W = LEN_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_src_base,
    input  logic [ADDR_W-1:0] cfg_dst_base,
    input  logic [LEN_W-1:0]  cfg_max_len,
    input  logic [2:0]        cfg_len_mode,
    input  logic              cfg_word,
    input  logic              cfg_n7,
    input  logic              cfg_repeat,
    input  logic              cfg_irq_mask,
    input  logic              irq_en,
    input  logic              arm_set,
    input  logic              trig,
    input  logic              done_clr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              chan_armed,
    output logic              chan_busy,
    output logic              chan_done,
    output logic              dma_flag,
    output logic              dma_irq
);
    typedef struct packed {
        vdma_st_e          st;
        logic              armed;
        logic              first;
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic [CNT_W-1:0]  units;
        logic [DATA_W-1:0] data;
    } chan_t;

    chan_t r_d, r_q;
    logic  fin;
    logic  var_mode;
    logic [CNT_W-1:0]  fixed_cnt, var_cnt;
    logic [ADDR_W-1:0] step;

    vdma_len_calc #(.LEN_W(LEN_W), .DATA_W(DATA_W), .WORD_N_W(WORD_N_W)) u_len (
        .len_mode   (cfg_len_mode),
        .max_len    (cfg_max_len),
        .word_mode  (cfg_word),
        .n7_sel     (cfg_n7),
        .first_unit (mem_rdata),
        .var_mode   (var_mode),
        .fixed_cnt  (fixed_cnt),
        .var_cnt    (var_cnt)
    );

    assign step = cfg_word ? ADDR_W'(2) : ADDR_W'(1);

    always_comb begin
        r_d = r_q;
        fin = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (arm_set) begin
                    r_d.armed = 1'b1;
                    r_d.src   = cfg_src_base;
                    r_d.dst   = cfg_dst_base;
                end else if (trig && r_q.armed) begin
                    r_d.units = '0;
                    r_d.first = 1'b1;
                    r_d.cnt   = fixed_cnt;
                    if (!var_mode && fixed_cnt == '0) r_d.st = ST_FIN;
                    else                               r_d.st = ST_RD;
                end
            end
            ST_RD: begin
                if (mem_ack) begin
                    r_d.data  = cfg_word ? mem_rdata : DATA_W'(mem_rdata[7:0]);
                    r_d.src   = r_q.src + step;
                    r_d.first = 1'b0;
                    r_d.st    = ST_WR;
                    if (r_q.first && var_mode) begin
                        r_d.cnt = var_cnt;
                        if (var_cnt == '0) r_d.st = ST_FIN;
                    end
                end
            end
            ST_WR: begin
                if (mem_ack) begin
                    r_d.dst   = r_q.dst + step;
                    r_d.units = r_q.units + CNT_W'(1);
                    if (r_q.units + CNT_W'(1) == r_q.cnt) r_d.st = ST_FIN;
                    else                                   r_d.st = ST_RD;
                end
            end
            default: begin
                fin  = 1'b1;
                r_d.st = ST_IDLE;
                if (cfg_repeat) begin
                    r_d.src = cfg_src_base;
                    r_d.dst = cfg_dst_base;
                end else begin
                    r_d.armed = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '{st: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    vdma_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .fin      (fin),
        .irq_mask (cfg_irq_mask),
        .irq_en   (irq_en),
        .clr      (done_clr),
        .done     (chan_done),
        .flag     (dma_flag),
        .irq      (dma_irq)
    );

    assign mem_req    = (r_q.st == ST_RD) || (r_q.st == ST_WR);
    assign mem_we     = (r_q.st == ST_WR);
    assign mem_addr   = mem_we ? r_q.dst : r_q.src;
    assign mem_wdata  = r_q.data;
    assign chan_armed = r_q.armed;
    assign chan_busy  = (r_q.st != ST_IDLE);

    // R12
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
    // R6
    unit_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WR) |-> (r_q.units < r_q.cnt));
    // R10
    busy_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chan_busy |-> chan_armed);
    // R11
    trig_disarmed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_busy && !chan_armed && trig && !arm_set) |=> !chan_busy);
    // R7
    zero_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_FIN && r_q.units == '0) |-> !$past(mem_we));
endmodule

// File: tb/tb_vlen_dma_chan.sv
module tb_vlen_dma_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cfg_src_base = '0, cfg_dst_base = '0;
    logic [12:0] cfg_max_len = '0;
    logic [2:0]  cfg_len_mode = '0;
    logic        cfg_word = 0, cfg_n7 = 0, cfg_repeat = 0, cfg_irq_mask = 0;
    logic        irq_en = 0, arm_set = 0, trig = 0, done_clr = 0;
    logic        mem_req, mem_we, mem_ack;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        chan_armed, chan_busy, chan_done, dma_flag, dma_irq;

    logic [15:0] mem [0:1023];
    int wcnt = 0;
    int total = 0, bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    vlen_dma_chan dut (.*);

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            mem_ack   <= 1'b0;
            mem_rdata <= '0;
        end else begin
            mem_ack <= mem_req && !mem_ack;
            if (mem_req && !mem_ack) begin
                if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
                else        mem_rdata <= mem[mem_addr[9:0]];
            end
            if (mem_req && mem_we && mem_ack) wcnt <= wcnt + 1;
        end
    end

    task automatic chk(input string rq, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", rq, act, exp);
        end
    endtask

    task automatic cfg(input logic [15:0] s, input logic [15:0] d, input int len,
                       input logic [2:0] code, input logic w, input logic n7,
                       input logic rep, input logic mask, input logic gie);
        @(negedge clk);
        cfg_src_base = s; cfg_dst_base = d; cfg_max_len = 13'(len);
        cfg_len_mode = code; cfg_word = w; cfg_n7 = n7; cfg_repeat = rep;
        cfg_irq_mask = mask; irq_en = gie;
        arm_set = 1; @(negedge clk); arm_set = 0;
        done_clr = 1; @(negedge clk); done_clr = 0;
    endtask

    task automatic fill(input int s, input int d, input int n, input logic [15:0] first, input logic w);
        int st = w ? 2 : 1;
        for (int i = 0; i < n; i++) begin
            mem[s + i*st] = (i == 0) ? first : 16'(16'hA500 + i*13);
            mem[d + i*st] = 16'h0;
        end
    endtask

    task automatic run(input string rq, input int exp_w);
        int t = 0;
        @(negedge clk); wcnt = 0;
        trig = 1; @(negedge clk); trig = 0;
        while (!chan_done && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        chk({rq, " done"}, chan_done, 1);
        chk({rq, " writes"}, wcnt, exp_w);
    endtask

    task automatic dst_chk(input string rq, input int s, input int d, input int n, input logic w);
        int st = w ? 2 : 1;
        int errs = 0;
        for (int i = 0; i < n; i++) begin
            logic [15:0] e = w ? mem[s + i*st] : {8'h00, mem[s + i*st][7:0]};
            if (mem[d + i*st] !== e) errs++;
        end
        chk({rq, " dst data"}, errs, 0);
    endtask

    task automatic t_reset();
        chk("R8 reset done", chan_done, 0);
        chk("R10 reset armed", chan_armed, 0);
        chk("R12 reset req", mem_req, 0);
        chk("R9 reset irq", dma_irq, 0);
    endtask

    task automatic t_disarmed();
        // R11: trigger while disarmed is ignored
        @(negedge clk); wcnt = 0;
        trig = 1; @(negedge clk); trig = 0;
        repeat (10) @(negedge clk);
        chk("R11 disarmed busy", chan_busy, 0);
        chk("R11 disarmed writes", wcnt, 0);
    endtask

    task automatic t_fixed();
        // R1: code 000 and 111 copy max_len units
        fill(16'h10, 16'h200, 8, 16'h00FE, 0);
        cfg(16'h10, 16'h200, 4, 3'b000, 0, 0, 0, 1, 1);
        run("R1 fixed000", 4);
        dst_chk("R6 fixed000", 16'h10, 16'h200, 4, 0);
        chk("R10 single shot disarm", chan_armed, 0);
        chk("R9 irq mask1 en1", dma_irq, 1);
        fill(16'h10, 16'h200, 8, 16'h00FE, 0);
        cfg(16'h10, 16'h200, 5, 3'b111, 0, 0, 0, 0, 1);
        run("R1 fixed111", 5);
        chk("R9 flag mask0", dma_flag, 0);
        cfg(16'h10, 16'h200, 0, 3'b000, 0, 0, 0, 0, 0);
        run("R1 fixed zero", 0);
    endtask

    task automatic t_var();
        fill(16'h10, 16'h200, 12, 16'h0003, 0);
        cfg(16'h10, 16'h200, 10, 3'b001, 0, 0, 0, 0, 0);
        run("R2 plus1", 4);
        dst_chk("R6 plus1", 16'h10, 16'h200, 4, 0);
        fill(16'h10, 16'h200, 12, 16'h0005, 0);
        cfg(16'h10, 16'h200, 10, 3'b010, 0, 0, 0, 0, 0);
        run("R2 plus0", 5);
        fill(16'h10, 16'h200, 12, 16'h0002, 0);
        cfg(16'h10, 16'h200, 10, 3'b011, 0, 0, 0, 0, 0);
        run("R2 plus2", 4);
        fill(16'h10, 16'h200, 12, 16'h0002, 0);
        cfg(16'h10, 16'h200, 10, 3'b100, 0, 0, 0, 0, 0);
        run("R2 plus3", 5);
        // R3: n=20 >= max 6 clamps to 6
        fill(16'h10, 16'h200, 24, 16'h0014, 0);
        cfg(16'h10, 16'h200, 6, 3'b001, 0, 0, 0, 0, 0);
        run("R3 clamp", 6);
    endtask

    task automatic t_nsel();
        // R4: 0x83 gives n=3 with 7-bit select, n=131 (clamped to 100) otherwise
        fill(16'h10, 16'h200, 110, 16'h5583, 0);
        cfg(16'h10, 16'h200, 100, 3'b010, 0, 1, 0, 0, 0);
        run("R4 n7", 3);
        dst_chk("R4 byte upper zero", 16'h10, 16'h200, 3, 0);
        fill(16'h10, 16'h200, 110, 16'h5583, 0);
        cfg(16'h10, 16'h200, 100, 3'b010, 0, 0, 0, 0, 0);
        run("R4 n8", 100);
    endtask

    task automatic t_word();
        // R5: 0xE005 gives n=5 from 13 bits, step 2
        fill(16'h20, 16'h300, 8, 16'hE005, 1);
        cfg(16'h20, 16'h300, 50, 3'b010, 1, 0, 0, 0, 0);
        run("R5 word", 5);
        dst_chk("R5 word", 16'h20, 16'h300, 5, 1);
        chk("R6 word no overrun", int'(mem[16'h300 + 10]), 0);
    endtask

    task automatic t_zero();
        // R7: n=0 with code 010 ends with no write
        fill(16'h10, 16'h200, 4, 16'h0000, 0);
        cfg(16'h10, 16'h200, 10, 3'b010, 0, 0, 0, 0, 0);
        run("R7 zero", 0);
        chk("R7 dst untouched", int'(mem[16'h200]), 0);
    endtask

    task automatic t_repeat();
        // R10: repeat keeps armed and reloads start addresses; R11 busy trig ignored
        int t = 0;
        fill(16'h10, 16'h200, 6, 16'h0011, 0);
        cfg(16'h10, 16'h200, 3, 3'b000, 0, 0, 1, 1, 0);
        run("R10 repeat first", 3);
        chk("R10 still armed", chan_armed, 1);
        chk("R9 flag set irq off", dma_flag, 1);
        chk("R9 irq gated", dma_irq, 0);
        @(negedge clk); done_clr = 1; @(negedge clk); done_clr = 0;
        chk("R8 clr done", chan_done, 0);
        chk("R8 clr flag", dma_flag, 0);
        for (int i = 0; i < 3; i++) mem[16'h200 + i] = 16'h0;
        @(negedge clk); wcnt = 0;
        trig = 1; @(negedge clk); trig = 0;
        repeat (3) @(negedge clk);
        trig = 1; @(negedge clk); trig = 0;
        while (!chan_done && t < 5000) begin @(negedge clk); t++; end
        repeat (30) @(negedge clk);
        chk("R11 busy trig writes", wcnt, 3);
        chk("R11 busy trig idle", chan_busy, 0);
        dst_chk("R10 reload", 16'h10, 16'h200, 3, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_disarmed();
        t_fixed();
        t_var();
        t_nsel();
        t_word();
        t_zero();
        t_repeat();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog act=%0d exp=0", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule